// File: doc/BRIEF.md
# Register-File Byte Burst Mover

This block copies a run of bytes between a general register file and a byte-addressed data memory. It treats the register file as a flat space of `RF_WORDS*4` bytes. It can also overwrite a run of register bytes with all-zeros or all-ones, and those two operations make no memory access. A command selects the operation, the first register byte, the memory base, an 8-bit offset and a byte count.

The memory base is either a value carried with the command or an entry of a built-in table of constant pointers. The byte count is either an immediate or one byte lane of register 0. The engine latches the command, raises `busy`, moves one byte per cycle whenever the memory can take it, and ends with a one-cycle `done`. If the count is illegal, the engine answers at once with `done` and `err`. In that case it touches nothing and never hangs.

The register file and the memory sit outside the block. The engine drives a byte address with a write strobe into the register file and takes a combinational byte read back. The memory port is a single-byte request qualified by `mem_ready`.

Top module: `rf_burst_engine`

## Requirements
- R1: A command with `cmd_valid` high while `busy` is low is accepted at that clock edge, and `busy` is high from the next cycle until the last byte has moved. A `cmd_valid` seen while `busy` is high is ignored and has no effect on any register or memory byte.
- R2: Load (`cmd_op`=0) writes the byte at memory address base+offset+i into register byte (start+i) mod 128, for i from 0 to length-1.
- R3: Store (`cmd_op`=1) writes register byte (start+i) mod 128 into memory address base+offset+i. No register byte is written.
- R4: Register byte address a names register a/4, bits 8*(a%4)+7 down to 8*(a%4), so byte 0 of a register is bits 7:0. A burst that passes byte 3 of one register continues at byte 0 of the next.
- R5: Register byte addresses wrap from 127 to 0 inside a burst.
- R6: With `cmd_len_sel_reg`=0 the length is `cmd_len_imm`. With `cmd_len_sel_reg`=1 the length is lane k=`cmd_len_lane` of `r0_value`, which is bits 8k+7:8k.
- R7: With `cmd_base_is_ct`=0 the base is `cmd_base`. With `cmd_base_is_ct`=1 the base is table entry n=`cmd_ct_index`, which equals CT_ORIGIN + n*CT_STRIDE (defaults 0x100 and 0x40).
- R8: A load or store moves one byte on each cycle with `mem_req` and `mem_ready` both high. While `mem_ready` is low, the memory and register addresses hold. With `mem_ready` held high, `done` arrives exactly length cycles after the accepting edge.
- R9: On the cycle `busy` drops, `done` is high for exactly one cycle, with `err` low.
- R10: A length of 0 or above 124, from either source, gives `done` and `err` high for one cycle in the cycle after acceptance. `busy` stays low, and no register or memory byte changes.
- R11: Clear (`cmd_op`=2) writes 0x00 and fill (`cmd_op`=3) writes 0xFF into register bytes start..start+length-1 (mod 128). These make no memory request and take one byte per cycle whatever `mem_ready` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 load, 1 store, 2 clear, 3 fill |
| cmd_len_sel_reg | input | 1 | Take the length from a lane of register 0 |
| cmd_len_lane | input | 2 | Lane of register 0 used for the length |
| cmd_len_imm | input | 8 | Immediate length |
| cmd_rf_start | input | 7 | First register byte address |
| cmd_base_is_ct | input | 1 | Take the base from the constant table |
| cmd_ct_index | input | 5 | Constant table entry |
| cmd_base | input | 32 | Base address when the table is not used |
| cmd_offset | input | 8 | Offset added to the base |
| r0_value | input | 32 | Current contents of register 0 |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal length, valid with `done` |
| rf_addr | output | 7 | Register-file byte address |
| rf_we | output | 1 | Register-file byte write strobe |
| rf_wdata | output | 8 | Register-file write byte |
| rf_rdata | input | 8 | Register-file byte at `rf_addr` (combinational) |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory byte at `mem_addr` (combinational) |
| mem_ready | input | 1 | Memory completes the request this cycle |

## Verification
Every input is driven on the falling edge, and each output is read on the next falling edge. An illegal command is therefore judged one half-cycle after its accepting edge: `done` and `err` must be high there, and `busy` low. A legal command must show `busy` at that same point. The bench then counts falling edges until `done` appears. That count must equal the length whenever the memory is always ready or the operation is a clear or fill. One falling edge later, `done` must have dropped. The bench keeps its own copies of the register file and the memory and updates them from the requirements. It compares the copies byte for byte against the modelled storage once the pulse is over, so every write from the final edge has landed.

// File: rtl/rbe_pkg.sv
// Shared types for the register-file burst mover.
// Assumes the encoding of cmd_op given in the block brief.
package rbe_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_CLEAR = 2'd2,
        OP_FILL  = 2'd3
    } rbe_op_e;
endpackage

// File: rtl/rbe_len_resolve.sv
// Picks the burst length from the immediate or from a lane of register 0
// and flags lengths that are zero or above MAX_LEN.
// Assumes lane k of register 0 occupies bits 8k+7:8k.
module rbe_len_resolve #(
    parameter int LEN_W   = 8,
    parameter int LANES   = 4,
    parameter int MAX_LEN = 124,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic                    from_reg,
    input  logic [LANE_W-1:0]       lane,
    input  logic [LEN_W-1:0]        imm,
    input  logic [LANES*LEN_W-1:0]  r0,
    output logic [LEN_W-1:0]        len,
    output logic                    bad
);
    logic [LEN_W-1:0] lane_val [LANES];

    // Slice register 0 into its byte lanes.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_val[k] = r0[k*LEN_W +: LEN_W];
    end

    // Choose the source and judge legality.
    always_comb begin
        len = from_reg ? lane_val[lane] : imm;
        bad = (len == '0) || (len > LEN_W'(MAX_LEN));
    end
endmodule

// File: rtl/rbe_const_table.sv
// Read-only table of constant base pointers, computed from parameters:
// entry n holds ORIGIN + n*STRIDE. No storage, pure selection.
module rbe_const_table #(
    parameter int          ENTRIES = 32,
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] ORIGIN  = 32'h0000_0100,
    parameter logic [31:0] STRIDE  = 32'h0000_0040,
    localparam int         IDX_W   = $clog2(ENTRIES)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] base
);
    logic [ADDR_W-1:0] entry [ENTRIES];

    // Build each entry from the origin and stride.
    for (genvar n = 0; n < ENTRIES; n++) begin : g_ent
        assign entry[n] = ADDR_W'(ORIGIN + STRIDE * n);
    end

    // Select the requested entry.
    assign base = entry[idx];
endmodule

// File: rtl/rbe_seq.sv
// Burst sequencer: latches an accepted command, walks the register byte
// pointer (wrapping modulo the register space) and the memory pointer,
// counts the remaining bytes and produces the done/err pulses.
// Assumes the caller only raises start_ok or start_bad while run is low.
module rbe_seq
    import rbe_pkg::*;
#(
    parameter int RF_AW  = 7,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic              start_bad,
    input  rbe_op_e           op_in,
    input  logic [RF_AW-1:0]  rf_start,
    input  logic [ADDR_W-1:0] mem_start,
    input  logic [CNT_W-1:0]  len,
    input  logic              mem_ready,
    output logic              run,
    output rbe_op_e           op_q,
    output logic [RF_AW-1:0]  rf_ptr,
    output logic [ADDR_W-1:0] mem_ptr,
    output logic              step,
    output logic              done,
    output logic              err
);
    logic [CNT_W-1:0] remain;

    // A byte moves when running and either no memory is involved or it is ready.
    always_comb begin
        step = run && ((op_q == OP_CLEAR) || (op_q == OP_FILL) || mem_ready);
    end

    // Command capture, pointer advance and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            op_q    <= OP_LOAD;
            rf_ptr  <= '0;
            mem_ptr <= '0;
            remain  <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (start_bad) begin
                done <= 1'b1;
                err  <= 1'b1;
            end else if (start_ok) begin
                run     <= 1'b1;
                op_q    <= op_in;
                rf_ptr  <= rf_start;
                mem_ptr <= mem_start;
                remain  <= len;
            end else if (step) begin
                rf_ptr  <= rf_ptr + 1'b1;
                mem_ptr <= mem_ptr + 1'b1;
                remain  <= remain - 1'b1;
                if (remain == CNT_W'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rf_burst_engine.sv
// Top of the register-file burst mover. Resolves the length and the base,
// hands legal commands to the sequencer and steers the byte datapath
// between the register-file port and the memory port.
// Assumes rf_rdata and mem_rdata are combinational reads of the addresses
// driven this cycle, and that writes land at the clock edge.
module rf_burst_engine
    import rbe_pkg::*;
#(
    parameter int          RF_WORDS   = 32,
    parameter int          WORD_BYTES = 4,
    parameter int          ADDR_W     = 32,
    parameter int          MAX_LEN    = 124,
    parameter int          CT_ENTRIES = 32,
    parameter logic [31:0] CT_ORIGIN  = 32'h0000_0100,
    parameter logic [31:0] CT_STRIDE  = 32'h0000_0040,
    localparam int         RF_BYTES   = RF_WORDS * WORD_BYTES,
    localparam int         RF_AW      = $clog2(RF_BYTES),
    localparam int         LANE_W     = $clog2(WORD_BYTES),
    localparam int         CT_W       = $clog2(CT_ENTRIES),
    localparam int         CNT_W      = $clog2(MAX_LEN + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_op,
    input  logic                      cmd_len_sel_reg,
    input  logic [LANE_W-1:0]         cmd_len_lane,
    input  logic [7:0]                cmd_len_imm,
    input  logic [RF_AW-1:0]          cmd_rf_start,
    input  logic                      cmd_base_is_ct,
    input  logic [CT_W-1:0]           cmd_ct_index,
    input  logic [ADDR_W-1:0]         cmd_base,
    input  logic [7:0]                cmd_offset,
    input  logic [WORD_BYTES*8-1:0]   r0_value,
    output logic                      busy,
    output logic                      done,
    output logic                      err,
    output logic [RF_AW-1:0]          rf_addr,
    output logic                      rf_we,
    output logic [7:0]                rf_wdata,
    input  logic [7:0]                rf_rdata,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [7:0]                mem_wdata,
    input  logic [7:0]                mem_rdata,
    input  logic                      mem_ready
);
    logic [7:0]        len_full;
    logic              len_bad;
    logic [ADDR_W-1:0] ct_base;
    logic [ADDR_W-1:0] mem_start;
    logic              accept;
    logic              run;
    logic              step;
    rbe_op_e           op_q;
    logic [RF_AW-1:0]  rf_ptr;
    logic [ADDR_W-1:0] mem_ptr;

    rbe_len_resolve #(
        .LEN_W   (8),
        .LANES   (WORD_BYTES),
        .MAX_LEN (MAX_LEN)
    ) u_len (
        .from_reg (cmd_len_sel_reg),
        .lane     (cmd_len_lane),
        .imm      (cmd_len_imm),
        .r0       (r0_value),
        .len      (len_full),
        .bad      (len_bad)
    );

    rbe_const_table #(
        .ENTRIES (CT_ENTRIES),
        .ADDR_W  (ADDR_W),
        .ORIGIN  (CT_ORIGIN),
        .STRIDE  (CT_STRIDE)
    ) u_ct (
        .idx  (cmd_ct_index),
        .base (ct_base)
    );

    // Accept only when idle; form the first memory address.
    always_comb begin
        accept    = cmd_valid && !run;
        mem_start = (cmd_base_is_ct ? ct_base : cmd_base) + ADDR_W'(cmd_offset);
    end

    rbe_seq #(
        .RF_AW  (RF_AW),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ok  (accept && !len_bad),
        .start_bad (accept && len_bad),
        .op_in     (rbe_op_e'(cmd_op)),
        .rf_start  (cmd_rf_start),
        .mem_start (mem_start),
        .len       (len_full[CNT_W-1:0]),
        .mem_ready (mem_ready),
        .run       (run),
        .op_q      (op_q),
        .rf_ptr    (rf_ptr),
        .mem_ptr   (mem_ptr),
        .step      (step),
        .done      (done),
        .err       (err)
    );

    // Steer bytes between the two ports according to the latched operation.
    always_comb begin
        busy      = run;
        rf_addr   = rf_ptr;
        mem_addr  = mem_ptr;
        mem_req   = run && ((op_q == OP_LOAD) || (op_q == OP_STORE));
        mem_we    = (op_q == OP_STORE);
        mem_wdata = rf_rdata;
        rf_we     = step && (op_q != OP_STORE);
        unique case (op_q)
            OP_LOAD:  rf_wdata = mem_rdata;
            OP_FILL:  rf_wdata = 8'hFF;
            default:  rf_wdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/rbe_checker.sv
// Protocol checker for rf_burst_engine, attached through bind below.
// Observes the ports only; assumes synchronous active-low reset.
module rbe_checker #(
    parameter int RF_AW  = 7,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              rf_we,
    input logic [RF_AW-1:0]  rf_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr
);
    // R1: no traffic on either port while idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we));

    // R8: a stalled request keeps both addresses.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> ($stable(mem_addr) && $stable(rf_addr)));

    // R8: a completed memory byte advances the memory address by one.
    p_mem_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!busy || (mem_addr == $past(mem_addr) + 1'b1)));

    // R5: register byte address steps by one modulo the register space.
    p_rf_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rf_we) |=> (!busy || (rf_addr == RF_AW'($past(rf_addr) + 1'b1))));

    // R9: the end of a burst is marked by done without err.
    p_end_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && !err));

    // R10: an error completion happens without ever entering a burst.
    p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !busy && !$past(busy)));

    // R2: a load writes the register file exactly when memory answers.
    p_load_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (rf_we == mem_ready));

    // R3: a store never writes the register file.
    p_store_no_rf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !rf_we);

    // R11: a burst without memory writes a register byte every cycle.
    p_fill_every_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req) |-> rf_we);
endmodule

bind rf_burst_engine rbe_checker #(
    .RF_AW  (RF_AW),
    .ADDR_W (ADDR_W)
) u_rbe_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rf_we     (rf_we),
    .rf_addr   (rf_addr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr)
);

// File: tb/tb_rf_burst_engine.sv
module tb_rf_burst_engine;
    localparam int          MEM_BYTES = 4096;
    localparam logic [31:0] CT_ORG    = 32'h100;
    localparam logic [31:0] CT_STP    = 32'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        cmd_len_sel_reg = 1'b0;
    logic [1:0]  cmd_len_lane = '0;
    logic [7:0]  cmd_len_imm = '0;
    logic [6:0]  cmd_rf_start = '0;
    logic        cmd_base_is_ct = 1'b0;
    logic [4:0]  cmd_ct_index = '0;
    logic [31:0] cmd_base = '0;
    logic [7:0]  cmd_offset = '0;
    logic [31:0] r0_value;
    logic        busy, done, err;
    logic [6:0]  rf_addr;
    logic        rf_we;
    logic [7:0]  rf_wdata, rf_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;
    logic        seed_now = 1'b0;

    logic [7:0] rf_m  [0:127];
    logic [7:0] mem_m [0:MEM_BYTES-1];
    logic [7:0] exp_rf  [0:127];
    logic [7:0] exp_mem [0:MEM_BYTES-1];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rf_burst_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_len_sel_reg(cmd_len_sel_reg), .cmd_len_lane(cmd_len_lane),
        .cmd_len_imm(cmd_len_imm), .cmd_rf_start(cmd_rf_start),
        .cmd_base_is_ct(cmd_base_is_ct), .cmd_ct_index(cmd_ct_index),
        .cmd_base(cmd_base), .cmd_offset(cmd_offset), .r0_value(r0_value),
        .busy(busy), .done(done), .err(err), .rf_addr(rf_addr), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // Storage models around the engine.
    assign rf_rdata  = rf_m[rf_addr];
    assign mem_rdata = mem_m[mem_addr[11:0]];
    assign r0_value  = {rf_m[3], rf_m[2], rf_m[1], rf_m[0]};

    always @(posedge clk) begin
        if (seed_now) begin
            for (int i = 0; i < 128; i++) rf_m[i] <= 8'($urandom);
            for (int i = 0; i < MEM_BYTES; i++) mem_m[i] <= 8'($urandom);
            rf_m[0] <= 8'd5;
            rf_m[1] <= 8'd0;
            rf_m[2] <= 8'd9;
            rf_m[3] <= 8'd200;
        end else begin
            if (rf_we) rf_m[rf_addr] <= rf_wdata;
            if (mem_req && mem_ready && mem_we) mem_m[mem_addr[11:0]] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic compare_state(input string req);
        int bad_rf = 0;
        int bad_mem = 0;
        for (int i = 0; i < 128; i++) if (rf_m[i] !== exp_rf[i]) bad_rf++;
        for (int i = 0; i < MEM_BYTES; i++) if (mem_m[i] !== exp_mem[i]) bad_mem++;
        chk(bad_rf == 0, req, "register bytes differing", bad_rf, 0);
        chk(bad_mem == 0, req, "memory bytes differing", bad_mem, 0);
    endtask

    // rdy_mode: 0 ready always, 1 random, 2 never ready.
    task automatic run_cmd(input int op, input bit from_reg, input int lane,
                           input int imm, input int start, input bit use_ct,
                           input int ctix, input int base, input int off,
                           input int rdy_mode, input bit poke, input string req);
        int len;
        bit bad;
        int maddr;
        int cnt;
        len   = from_reg ? int'(exp_rf[lane]) : imm;
        bad   = (len == 0) || (len > 124);
        maddr = (use_ct ? int'(CT_ORG) + ctix * int'(CT_STP) : base) + off;
        if (!bad) begin
            for (int i = 0; i < len; i++) begin
                int ra = (start + i) % 128;
                int ma = (maddr + i) & (MEM_BYTES - 1);
                case (op)
                    0: exp_rf[ra] = exp_mem[ma];
                    1: exp_mem[ma] = exp_rf[ra];
                    2: exp_rf[ra] = 8'h00;
                    default: exp_rf[ra] = 8'hFF;
                endcase
            end
        end
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = 2'(op);
        cmd_len_sel_reg = from_reg;
        cmd_len_lane = 2'(lane);
        cmd_len_imm = 8'(imm);
        cmd_rf_start = 7'(start);
        cmd_base_is_ct = use_ct;
        cmd_ct_index = 5'(ctix);
        cmd_base = base;
        cmd_offset = 8'(off);
        mem_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : 1'($urandom % 3 != 0);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (bad) begin
            chk(done && err && !busy, "R10", "done/err/busy after illegal length",
                {done, err, busy}, 3'b110);
            @(negedge clk);
            chk(!done, "R10", "done after error pulse", done, 0);
        end else begin
            chk(busy && !done, "R1", "busy/done after accept", {busy, done}, 2'b10);
            cnt = 0;
            while (!done && cnt < 2000) begin
                if (rdy_mode == 1) mem_ready = 1'($urandom % 3 != 0);
                if (poke && cnt == 1) begin
                    cmd_valid = 1'b1;
                    cmd_op = 2'd3;
                    cmd_len_sel_reg = 1'b0;
                    cmd_len_imm = 8'd50;
                    cmd_rf_start = 7'd0;
                end else begin
                    cmd_valid = 1'b0;
                end
                @(negedge clk);
                cnt++;
            end
            cmd_valid = 1'b0;
            if (rdy_mode == 0 || op >= 2)
                chk(cnt == len, "R8", "cycles from accept to done", cnt, len);
            chk(done && !busy && !err, "R9", "done/busy/err at end",
                {done, busy, err}, 3'b100);
            @(negedge clk);
            chk(!done, "R9", "done width", done, 0);
            mem_ready = 1'b1;
        end
        compare_state(req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        seed_now = 1'b1;
        repeat (3) @(negedge clk);
        seed_now = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(!busy && !done && !err && !mem_req && !rf_we, "R1", "outputs after reset",
            {busy, done, err, mem_req, rf_we}, 0);
        for (int i = 0; i < 128; i++) exp_rf[i] = rf_m[i];
        for (int i = 0; i < MEM_BYTES; i++) exp_mem[i] = mem_m[i];

        // Length from register 0 lanes (lane k = bits 8k+7:8k).
        run_cmd(0, 1, 2, 0, 16, 0, 0, 'h400, 3, 0, 0, "R6 lane2 load");
        run_cmd(1, 1, 0, 0, 24, 0, 0, 'h500, 0, 0, 0, "R6 lane0 store");
        run_cmd(0, 1, 1, 0, 8, 0, 0, 'h600, 0, 0, 0, "R10 zero lane");
        run_cmd(0, 1, 3, 0, 8, 0, 0, 'h600, 0, 0, 0, "R10 lane above limit");
        // Directed loads, stores and boundaries.
        run_cmd(0, 0, 0, 8, 8, 0, 0, 'h200, 5, 0, 0, "R2 load");
        run_cmd(1, 0, 0, 12, 20, 0, 0, 'h300, 0, 0, 0, "R3 store");
        run_cmd(0, 0, 0, 7, 6, 0, 0, 'h700, 9, 0, 0, "R4 register crossing");
        run_cmd(0, 0, 0, 124, 4, 1, 31, 0, 255, 0, 0, "R7 table base max length");
        run_cmd(1, 0, 0, 3, 40, 1, 0, 0, 1, 0, 0, "R7 table entry 0");
        run_cmd(0, 0, 0, 125, 8, 0, 0, 'h200, 0, 0, 0, "R10 length 125");
        run_cmd(1, 0, 0, 0, 8, 0, 0, 'h200, 0, 0, 0, "R10 immediate zero");
        run_cmd(0, 0, 0, 10, 124, 0, 0, 'h800, 0, 0, 0, "R5 load wrap");
        run_cmd(1, 0, 0, 5, 126, 0, 0, 'h900, 0, 0, 0, "R5 store wrap");
        run_cmd(2, 0, 0, 6, 40, 0, 0, 0, 0, 1, 0, "R11 clear");
        run_cmd(3, 0, 0, 124, 50, 0, 0, 0, 0, 2, 0, "R11 fill while not ready");
        run_cmd(0, 0, 0, 20, 60, 0, 0, 'hA00, 7, 1, 0, "R8 load with stalls");
        run_cmd(1, 0, 0, 20, 70, 0, 0, 'hB00, 7, 1, 1, "R1 command while busy");
        run_cmd(1, 0, 0, 1, 127, 0, 0, 'hC00, 0, 0, 0, "R3 single byte");

        // Constrained random mix.
        for (int n = 0; n < 30; n++) begin
            int ln = ($urandom % 16 == 0) ? int'($urandom % 256) : 1 + int'($urandom % 124);
            run_cmd(int'($urandom % 4), 1'($urandom % 4 == 0), int'($urandom % 4), ln,
                    int'($urandom % 128), 1'($urandom % 2), int'($urandom % 32),
                    int'($urandom % 3000), int'($urandom % 256), int'($urandom % 2),
                    0, "R2 R3 R8 random");
        end
        finish_up();
    end
endmodule